// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Front End

This block is the clocked front end of a small synchronous static RAM. On each rising clock edge it samples three chip-select inputs, a word address, write data and the write controls. A selected cycle is either a write or a read. A write stores the whole word when the global write control is low. Otherwise it stores only the byte lanes picked by the byte-write enable together with the per-lane selects. Every other selected cycle is a read, and a cycle that is not selected is a deselect.

Read data reaches the output in one of two ways, chosen by a mode input. In registered mode the data passes through an output register and is first seen at the second rising edge after the command edge, which gives 3-1-1-1 burst timing. In flow-through mode the data goes around that register and is seen at the first following edge, which gives 2-1-1-1 timing. Deselects travel down the same pipeline as reads. After a read, the bus stays driven with the last read data through the whole cycle that follows a deselect edge, and it turns off just after the next edge.

The output drive is reported on a separate enable, so the pad ring that owns the tri-state buffers can use it. The output enable and the sleep input act on that drive without waiting for a clock edge. Commands sampled while sleep is high are ignored, and the array keeps its contents. Burst address counting is not part of the block: the system supplies a complete address on every cycle.

Top module: `sram_front_top`

## Requirements
- R1: The device is selected only when selA_n is 0, selB is 1 and selC_n is 0. A write command in any other combination leaves the array unchanged.
- R2: When wrAll_n is 0 on a selected edge, every byte of the word at addr is written from dataIn, whatever wrByteEn_n and byteSel_n are.
- R3: When wrAll_n is 1, wrByteEn_n is 0 and at least one byteSel_n bit is 0, only the lanes whose byteSel_n bit is 0 are written. Lane i is bits [8i+7:8i]. With wrByteEn_n at 1, or with all byteSel_n bits at 1, the selected cycle is a read.
- R4: With pipeMode at 1, read data is valid and dataOutEn is high in the second clock cycle after the command edge. With pipeMode at 0, both hold in the first cycle after the command edge.
- R5: Reads issued on consecutive edges each return their own word, one word per cycle, in both modes.
- R6: dataOutEn is low throughout the cycle that follows a write command edge.
- R7: When a read is followed by a deselect edge, dataOutEn stays high and dataOut keeps that read's data for the cycle after the deselect edge. After two deselect edges in a row, dataOutEn is low.
- R8: While outEn_n is 1, dataOutEn is low without waiting for a clock edge, and the stored data is not affected.
- R9: While sleep is 1, dataOutEn is low. Read and write commands sampled with sleep at 1 are ignored, and the array contents are kept.
- R10: While rstN is low and on the first edge after it rises, dataOutEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of the control pipeline |
| pipeMode | input | 1 | 1 = registered read path, 0 = flow-through read path |
| selA_n | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selC_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Write data |
| wrAll_n | input | 1 | Global write of all lanes, active low |
| wrByteEn_n | input | 1 | Byte-write enable, active low |
| byteSel_n | input | LANES | Per-lane byte selects, active low |
| outEn_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dataOut | output | DATA_W | Read data |
| dataOutEn | output | 1 | High when the data bus is driven |

## Verification
The bound checker checks the drive timing on every cycle. It checks the read latency in each mode, the quiet bus after a write edge, the one-cycle hold and the shutdown after deselect edges, the immediate effect of output enable and sleep, and the quiet bus in reset. None of these checks looks at data values. The bench keeps a reference memory, so only its scenarios show which lanes a write touches, that a global write overrides the lane selects, that writes while deselected or asleep leave the array untouched, and that each read in a back-to-back stream carries its own word.

// File: rtl/sram_front_pkg.sv
`timescale 1ns/1ps
package sram_front_pkg;

  // strobes handed from the control pipeline to the datapath
  typedef struct packed {
    logic wrEn;    // write the current edge's data into the array
    logic rdLoad;  // a read sits in stage one: load the output register
    logic bypass;  // flow-through mode with a read in stage one
  } dpStrobe_t;

endpackage

// File: rtl/sram_front_ctl.sv
`timescale 1ns/1ps
module sram_front_ctl
  import sram_front_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pipeMode,
  input  logic             selA_n,
  input  logic             selB,
  input  logic             selC_n,
  input  logic             wrAll_n,
  input  logic             wrByteEn_n,
  input  logic [LANES-1:0] byteSel_n,
  input  logic             outEn_n,
  input  logic             sleep,
  output dpStrobe_t        strobe,
  output logic [LANES-1:0] wrMask,
  output logic             drvOn
);

  logic chipSel, awake, byteReq;
  logic wrCmd, rdCmd, dsCmd;
  logic rdS1, rdS2, dsS1, wrS1;
  logic lineBusy;

  // command decode on the sampled inputs
  always_comb begin
    chipSel = !selA_n && selB && !selC_n;
    awake   = !sleep;
    byteReq = !wrByteEn_n && (byteSel_n != {LANES{1'b1}});
    wrCmd   = chipSel && awake && (!wrAll_n || byteReq);
    rdCmd   = chipSel && awake && !wrCmd;
    dsCmd   = !chipSel && awake;
    wrMask  = !wrAll_n ? {LANES{1'b1}} : ~byteSel_n;
  end

  // read and deselect travel through the same two stages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdS1 <= 1'b0;
      rdS2 <= 1'b0;
      dsS1 <= 1'b0;
      wrS1 <= 1'b0;
    end else begin
      rdS1 <= rdCmd;
      rdS2 <= rdS1;
      dsS1 <= dsCmd;
      wrS1 <= wrCmd;
    end
  end

  always_comb begin
    strobe.wrEn   = wrCmd;
    strobe.rdLoad = rdS1;
    strobe.bypass = !pipeMode && rdS1;
    if (pipeMode)
      lineBusy = rdS2;
    else
      lineBusy = rdS1 || (dsS1 && rdS2);
    // output enable and sleep gate the drive without a clock
    drvOn = !outEn_n && !sleep && !wrS1 && lineBusy;
  end

endmodule

// File: rtl/sram_front_dp.sv
`timescale 1ns/1ps
module sram_front_dp
  import sram_front_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  dpStrobe_t         strobe,
  input  logic [LANES-1:0]  wrMask,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bitMask;
  logic [ADDR_W-1:0] addrS1;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] outReg;

  // spread each lane's write bit over its data bits
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bitMask[g*LANE_W +: LANE_W] = {LANE_W{wrMask[g]}};
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn)
      mem[addr] <= (mem[addr] & ~bitMask) | (dataIn & bitMask);
  end

  always_ff @(posedge clk) begin
    addrS1 <= addr;
  end

  assign rdData = mem[addrS1];

  always_ff @(posedge clk) begin
    if (strobe.rdLoad)
      outReg <= rdData;
  end

  assign dataOut = strobe.bypass ? rdData : outReg;

endmodule

// File: rtl/sram_front_top.sv
`timescale 1ns/1ps
module sram_front_top
  import sram_front_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              selA_n,
  input  logic              selB,
  input  logic              selC_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              wrAll_n,
  input  logic              wrByteEn_n,
  input  logic [LANES-1:0]  byteSel_n,
  input  logic              outEn_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  dpStrobe_t        strobe;
  logic [LANES-1:0] wrMask;

  sram_front_ctl #(.LANES(LANES)) ctl_i (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode),
    .selA_n(selA_n), .selB(selB), .selC_n(selC_n),
    .wrAll_n(wrAll_n), .wrByteEn_n(wrByteEn_n), .byteSel_n(byteSel_n),
    .outEn_n(outEn_n), .sleep(sleep),
    .strobe(strobe), .wrMask(wrMask), .drvOn(dataOutEn)
  );

  sram_front_dp #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .strobe(strobe), .wrMask(wrMask),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut)
  );

endmodule

// File: rtl/sram_front_chk.sv
`timescale 1ns/1ps
module sram_front_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             pipeMode,
  input logic             selA_n,
  input logic             selB,
  input logic             selC_n,
  input logic             wrAll_n,
  input logic             wrByteEn_n,
  input logic [LANES-1:0] byteSel_n,
  input logic             outEn_n,
  input logic             sleep,
  input logic             dataOutEn
);

  logic chipOn, isWr, isRd, isDs;

  // command classes taken from the port view only
  always_comb begin
    chipOn = rstN && !sleep && !selA_n && selB && !selC_n;
    isWr   = chipOn && (!wrAll_n || (!wrByteEn_n && (byteSel_n != {LANES{1'b1}})));
    isRd   = chipOn && !isWr;
    isDs   = rstN && !sleep && !(!selA_n && selB && !selC_n);
  end

  a_r4_pipe_latency: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $past(isRd, 2) && !$past(isWr) && !outEn_n && !sleep) |-> dataOutEn);

  a_r4_flow_latency: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && $past(isRd) && !outEn_n && !sleep) |-> dataOutEn);

  a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(isWr) |-> !dataOutEn);

  a_r7_deselect_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(isRd, 2) && $past(isDs) && !outEn_n && !sleep) |-> dataOutEn);

  a_r7_deselect_off: assert property (@(posedge clk) disable iff (!rstN)
    ($past(isDs) && $past(isDs, 2)) |-> !dataOutEn);

  a_r8_oe_off: assert property (@(posedge clk) disable iff (!rstN)
    outEn_n |-> !dataOutEn);

  a_r9_sleep_off: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dataOutEn);

  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(!rstN) |-> !dataOutEn);

endmodule

bind sram_front_top sram_front_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rstN(rstN), .pipeMode(pipeMode),
  .selA_n(selA_n), .selB(selB), .selC_n(selC_n),
  .wrAll_n(wrAll_n), .wrByteEn_n(wrByteEn_n), .byteSel_n(byteSel_n),
  .outEn_n(outEn_n), .sleep(sleep), .dataOutEn(dataOutEn)
);

// File: tb/sram_front_top_tb_top.sv
`timescale 1ns/1ps
module sram_front_top_tb_top;

  localparam int DATA_W = 32;
  localparam int LANES  = 4;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN, pipeMode, selA_n, selB, selC_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataIn;
  logic              wrAll_n, wrByteEn_n, outEn_n, sleep;
  logic [LANES-1:0]  byteSel_n;
  logic [DATA_W-1:0] dataOut;
  logic              dataOutEn;

  int    nCmp = 0;
  int    nBad = 0;
  string ctx  = "";

  // reference state
  logic [DATA_W-1:0] refMem [DEPTH];
  logic eRd1, eRd2, eDs1, eWr1;
  logic [DATA_W-1:0] eVal1, eVal2;

  always #2.5 clk = ~clk;

  sram_front_top #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode),
    .selA_n(selA_n), .selB(selB), .selC_n(selC_n),
    .addr(addr), .dataIn(dataIn), .wrAll_n(wrAll_n), .wrByteEn_n(wrByteEn_n),
    .byteSel_n(byteSel_n), .outEn_n(outEn_n), .sleep(sleep),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  function automatic logic [DATA_W-1:0] laneMask(input logic [LANES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction

  // reference model update at each edge, from the requirements
  always @(posedge clk) begin
    logic sel, wr, rd, ds;
    logic [LANES-1:0] m;
    if (!rstN) begin
      eRd1 = 0; eRd2 = 0; eDs1 = 0; eWr1 = 0;
    end else begin
      sel = !selA_n && selB && !selC_n && !sleep;
      wr  = sel && (!wrAll_n || (!wrByteEn_n && byteSel_n != '1));
      rd  = sel && !wr;
      ds  = !(!selA_n && selB && !selC_n) && !sleep;
      eRd2 = eRd1;
      if (eRd1) eVal2 = eVal1;
      if (rd) eVal1 = refMem[addr];
      if (wr) begin
        m = !wrAll_n ? '1 : ~byteSel_n;
        refMem[addr] = (refMem[addr] & ~laneMask(m)) | (dataIn & laneMask(m));
      end
      eRd1 = rd; eDs1 = ds; eWr1 = wr;
    end
  end

  task automatic checkOut();
    logic expDrv;
    logic [DATA_W-1:0] expData;
    string tag;
    expDrv = rstN && !outEn_n && !sleep && !eWr1 &&
             (pipeMode ? eRd2 : (eRd1 || (eDs1 && eRd2)));
    expData = (!pipeMode && eRd1) ? eVal1 : eVal2;
    if (!rstN) tag = "R10";
    else if (ctx != "") tag = ctx;
    else if (sleep) tag = "R9";
    else if (outEn_n) tag = "R8";
    else if (eWr1) tag = "R6";
    else if (eDs1 && eRd2 && !eRd1) tag = "R7";
    else tag = "R4";
    nCmp++;
    if (dataOutEn !== expDrv) begin
      nBad++;
      $display("FAIL %s: dataOutEn actual %0b expected %0b at %0t", tag, dataOutEn, expDrv, $time);
    end
    if (expDrv) begin
      nCmp++;
      if (dataOut !== expData) begin
        nBad++;
        $display("FAIL %s: dataOut actual %0h expected %0h at %0t", tag, dataOut, expData, $time);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    checkOut();
  endtask

  task automatic setIdle();
    selA_n = 1; selB = 0; selC_n = 0;
    wrAll_n = 1; wrByteEn_n = 1; byteSel_n = '1;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a);
    setIdle(); selA_n = 0; selB = 1; addr = a; tick();
  endtask

  task automatic doWrAll(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic [LANES-1:0] s);
    setIdle(); selA_n = 0; selB = 1; addr = a; dataIn = d;
    wrAll_n = 0; wrByteEn_n = 0; byteSel_n = s; tick();
  endtask

  task automatic doWrByte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic [LANES-1:0] s);
    setIdle(); selA_n = 0; selB = 1; addr = a; dataIn = d;
    wrByteEn_n = 0; byteSel_n = s; tick();
  endtask

  task automatic doIdle(input int n);
    for (int i = 0; i < n; i++) begin setIdle(); tick(); end
  endtask

  initial begin
    void'($urandom(32'd20241));
    rstN = 0; pipeMode = 1; outEn_n = 0; sleep = 0;
    addr = '0; dataIn = '0; setIdle();
    tick(); tick();                       // R10: quiet in reset
    rstN = 1;
    ctx = "R10"; tick(); ctx = "";

    for (int a = 0; a < DEPTH; a++) doWrAll(a[ADDR_W-1:0], $urandom, '1);
    doIdle(2);

    for (int m = 0; m < 2; m++) begin
      pipeMode = (m == 0);
      // R2: global write ignores the lane selects
      ctx = "R2"; doWrAll(4'd3, 32'hA1B2C3D4, 4'b1010); doRead(4'd3); doIdle(3);
      // R3: lanes 0 and 2 only; then byte-enable off or no lane selected is a read
      ctx = "R3"; doWrByte(4'd5, 32'h11223344, 4'b1010); doRead(4'd5); doIdle(3);
      setIdle(); selA_n = 0; selB = 1; addr = 4'd5; dataIn = '1; byteSel_n = 4'b0000; tick();
      doWrByte(4'd5, '1, 4'b1111); doIdle(3);
      // R1: every non-selecting enable pattern leaves the array alone
      ctx = "R1";
      for (int p = 0; p < 8; p++) begin
        if (p == 2) continue;
        {selA_n, selB, selC_n} = p[2:0];
        addr = 4'd6; dataIn = $urandom; wrAll_n = 0; wrByteEn_n = 0; byteSel_n = '0; tick();
      end
      doRead(4'd6); doIdle(3);
      // R5: back-to-back reads
      ctx = "R5"; for (int a = 0; a < 6; a++) doRead(a[ADDR_W-1:0]); doIdle(3);
      // R7: read then deselects
      ctx = "R7"; doRead(4'd9); doIdle(3);
      // R9: writes in sleep are dropped, contents kept
      ctx = "R9"; sleep = 1; doWrAll(4'd9, 32'hDEADBEEF, '0); doRead(4'd9); sleep = 0;
      doIdle(2); doRead(4'd9); doIdle(3);
      // R8: output enable off while a read would drive
      ctx = "R8"; outEn_n = 1; doRead(4'd2); doRead(4'd2); doIdle(1); outEn_n = 0;
      doRead(4'd2); doIdle(3);
      ctx = "";
    end

    // random mix in both modes
    for (int blk = 0; blk < 4; blk++) begin
      pipeMode = blk[0];
      for (int c = 0; c < 500; c++) begin
        int r;
        r = $urandom_range(0, 99);
        setIdle();
        addr = $urandom; dataIn = $urandom;
        if (r < 70) begin selA_n = 0; selB = 1; selC_n = 0; end
        else {selA_n, selB, selC_n} = $urandom;
        r = $urandom_range(0, 99);
        if (r < 15) wrAll_n = 0;
        else if (r < 35) begin wrByteEn_n = 0; byteSel_n = $urandom; end
        outEn_n = ($urandom_range(0, 99) < 8);
        sleep   = ($urandom_range(0, 99) < 4);
        tick();
      end
    end
    sleep = 0; outEn_n = 0;
    doIdle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #1000000;
    nBad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule